// File: doc/BRIEF.md
# Dual-Mode Timer With Converter Trigger

This block is a bus-mapped timer. A simple register port (address, write enable, write data, combinational read data) programs it. A configuration register selects its behaviour. Value 0 gives a 32-bit down-counter. It counts one system clock per step and signals a timeout after a programmed interval, either once or repeatedly. Value 1 gives a seconds counter that advances on a one-cycle strobe input and returns to zero once it passes a programmed match value. All other configuration values leave the timer idle.

A timeout or a return to zero sets a bit in a raw status register. A mask register selects which raw bits drive the level interrupt output. In countdown mode, an enable bit in the control register also makes each timeout emit a one-cycle pulse on a trigger output, meant to start a data converter. The interval and match registers are each held as two 16-bit halves. Registers outside the two modes (second-channel mode, prescaler slots) only store what is written to them.

Register offsets: configuration 0x00, mode A 0x04, mode B 0x08, control 0x0C, mask 0x18, raw status 0x1C, masked status 0x20, clear 0x24, interval 0x28, interval high 0x2C, match 0x30, match high 0x34, four storage slots 0x38/0x3C/0x40/0x44. Any other offset reads 0.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads 0, the timer is stopped, and irqOut and adcTrig are low.
- R2: Configuration (0x00), mode A (0x04), mode B (0x08), control (0x0C) and the four storage slots (0x38 to 0x44) read back the full 32-bit value last written. The clear register 0x24 and all unmapped offsets read 0.
- R3: A write to 0x28 stores bits 15:0 as the interval low half. It also stores bits 31:16 as the high half, but only while configuration is below 4. A read of 0x28 returns the low half, with the high half in bits 31:16 only while configuration is below 4. Offset 0x2C writes and reads the high half in bits 15:0. The match pair 0x30/0x34 follows the same rules.
- R4: With configuration 0, a write that changes control bit 0 from 0 to 1 loads the counter with the 32-bit interval N. A timeout then occurs on the Nth clock edge after that write and every N edges after that. An interval of 0 or 1 times out on every edge.
- R5: When mode A bit 0 is 1 (one-shot), a timeout clears control bit 0 and no further timeouts follow. When it is 0, the counter reloads from the interval and keeps running.
- R6: A timeout sets raw status bit 0. The bit reads at 0x1C from the cycle after the timeout edge.
- R7: When control bit 5 is 1, each countdown timeout drives adcTrig high for exactly the cycle after the timeout edge. When bit 5 is 0, or outside countdown mode, adcTrig stays low.
- R8: With configuration 1 and control bit 0 set, each cycle with secTick high adds one to the seconds count. If the result is greater than the 32-bit match value, the count becomes 0. A result of 0 sets raw status bit 3.
- R9: A control write with bit 0 equal to 0 stops the timer at that edge. No timeout and no seconds step happen on that edge or later. A later 0-to-1 write reloads the interval.
- R10: The mask register (0x18) keeps only bits 0, 1, 2, 4, 5 and 6 of the written value (write data AND 0x77).
- R11: irqOut is high exactly when raw AND mask is nonzero. Offset 0x20 reads raw AND mask, and offset 0x1C reads the raw bits 6:0.
- R12: Writing 1s to 0x24 clears the matching raw bits. A status event on the same edge wins over the clear.
- R13: Configuration values other than 0 and 1 leave the timer idle even with control bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the down-counter steps once per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (8) | Register byte offset |
| busWe | input | 1 | Write strobe, one register write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| secTick | input | 1 | One-cycle seconds strobe, synchronous to clk |
| irqOut | output | 1 | Level interrupt, raw AND mask nonzero |
| adcTrig | output | 1 | One-cycle converter trigger pulse |

## Verification
The hardest situations to reach are the ones where two things land on the same edge: a status event and a clear of the same bit, a one-shot timeout and a control write, or a stop write and a timeout that is due. Directed sequences first fix the timeout cadence, the one-shot end and the wrap of the seconds count. A long phase of random register traffic follows, with small intervals and frequent seconds strobes, so that these collisions happen many times. A behavioural model checks read data, irqOut and adcTrig on every cycle.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // register byte offsets
  localparam int OFS_CFG    = 'h00;
  localparam int OFS_MODEA  = 'h04;
  localparam int OFS_MODEB  = 'h08;
  localparam int OFS_CTRL   = 'h0C;
  localparam int OFS_MASK   = 'h18;
  localparam int OFS_RAW    = 'h1C;
  localparam int OFS_MSTAT  = 'h20;
  localparam int OFS_CLR    = 'h24;
  localparam int OFS_IVL    = 'h28;
  localparam int OFS_IVLHI  = 'h2C;
  localparam int OFS_MATCH  = 'h30;
  localparam int OFS_MATCHI = 'h34;
  localparam int OFS_SLOT0  = 'h38;

  localparam logic [31:0] CFG_COUNT = 32'd0;
  localparam logic [31:0] CFG_RTC   = 32'd1;
  localparam logic [31:0] CFG_SPLIT = 32'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCnt;
    logic runCnt;
    logic stepRtc;
  } gptStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic timeout;
    logic rtcZero;
  } gptEvent_t;
endpackage

// File: rtl/gpt_dp.sv
module gpt_dp
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gptStrobe_t            stb,
  input  logic [2*HALF_W-1:0]   reloadVal,
  input  logic [2*HALF_W-1:0]   matchVal,
  output gptEvent_t             evt
);
  localparam int DATA_W = 2 * HALF_W;

  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] rtcQ;
  logic              cntAtEnd;
  logic [DATA_W:0]   rtcInc;
  logic [DATA_W-1:0] rtcStepVal;

  always_comb begin
    cntAtEnd   = (cntQ <= DATA_W'(1));
    rtcInc     = {1'b0, rtcQ} + (DATA_W+1)'(1);
    rtcStepVal = (rtcInc > {1'b0, matchVal}) ? '0 : rtcInc[DATA_W-1:0];
    evt.timeout = stb.runCnt & cntAtEnd;
    evt.rtcZero = stb.stepRtc & (rtcStepVal == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      rtcQ <= '0;
    end else begin
      if (stb.loadCnt)
        cntQ <= reloadVal;
      else if (stb.runCnt)
        cntQ <= cntAtEnd ? reloadVal : cntQ - DATA_W'(1);
      if (stb.stepRtc)
        rtcQ <= rtcStepVal;
    end
  end
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16,
  parameter int STAT_W = 7,
  parameter int N_SLOT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [2*HALF_W-1:0]  busWdata,
  output logic [2*HALF_W-1:0]  busRdata,
  input  logic                 secTick,
  input  gptEvent_t            evt,
  output gptStrobe_t           stb,
  output logic [2*HALF_W-1:0]  reloadVal,
  output logic [2*HALF_W-1:0]  matchVal,
  output logic                 irqOut,
  output logic                 adcTrig
);
  localparam int DATA_W = 2 * HALF_W;
  localparam logic [STAT_W-1:0] MASK_KEEP = STAT_W'(7'h77);
  localparam int BIT_TIMEOUT = 0;
  localparam int BIT_RTC     = 3;
  localparam int CTL_RUN     = 0;
  localparam int CTL_TRIG    = 5;

  logic [DATA_W-1:0] cfgQ, modeAQ, modeBQ, ctrlQ;
  logic [STAT_W-1:0] maskQ, rawQ;
  logic [HALF_W-1:0] ivlLoQ, ivlHiQ, matLoQ, matHiQ;
  logic [DATA_W-1:0] slotQ [N_SLOT];
  logic              trigQ;

  logic ctrlWr, stopping, active, splitOff;
  logic [STAT_W-1:0] clrBits, setBits;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    splitOff = cfgQ < CFG_SPLIT;
    ctrlWr   = busWe && hit(busAddr, OFS_CTRL);
    stopping = ctrlWr && !busWdata[CTL_RUN];
    active   = ctrlQ[CTL_RUN] && !stopping;
    stb.loadCnt = ctrlWr && busWdata[CTL_RUN] && !ctrlQ[CTL_RUN];
    stb.runCnt  = active && (cfgQ == CFG_COUNT);
    stb.stepRtc = active && (cfgQ == CFG_RTC) && secTick;
    reloadVal = {ivlHiQ, ivlLoQ};
    matchVal  = {matHiQ, matLoQ};
    clrBits = (busWe && hit(busAddr, OFS_CLR)) ? busWdata[STAT_W-1:0] : '0;
    setBits = '0;
    setBits[BIT_TIMEOUT] = evt.timeout;
    setBits[BIT_RTC]     = evt.rtcZero;
    irqOut  = |(rawQ & maskQ);
    adcTrig = trigQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0; modeAQ <= '0; modeBQ <= '0; ctrlQ <= '0;
      maskQ <= '0; rawQ <= '0; trigQ <= 1'b0;
      ivlLoQ <= '0; ivlHiQ <= '0; matLoQ <= '0; matHiQ <= '0;
    end else begin
      rawQ  <= (rawQ & ~clrBits) | setBits;
      trigQ <= evt.timeout & ctrlQ[CTL_TRIG];
      if (ctrlWr)
        ctrlQ <= busWdata;
      else if (evt.timeout && modeAQ[0])
        ctrlQ[CTL_RUN] <= 1'b0;
      if (busWe) begin
        if (hit(busAddr, OFS_CFG))   cfgQ   <= busWdata;
        if (hit(busAddr, OFS_MODEA)) modeAQ <= busWdata;
        if (hit(busAddr, OFS_MODEB)) modeBQ <= busWdata;
        if (hit(busAddr, OFS_MASK))  maskQ  <= busWdata[STAT_W-1:0] & MASK_KEEP;
        if (hit(busAddr, OFS_IVL)) begin
          ivlLoQ <= busWdata[HALF_W-1:0];
          if (splitOff) ivlHiQ <= busWdata[DATA_W-1:HALF_W];
        end
        if (hit(busAddr, OFS_IVLHI)) ivlHiQ <= busWdata[HALF_W-1:0];
        if (hit(busAddr, OFS_MATCH)) begin
          matLoQ <= busWdata[HALF_W-1:0];
          if (splitOff) matHiQ <= busWdata[DATA_W-1:HALF_W];
        end
        if (hit(busAddr, OFS_MATCHI)) matHiQ <= busWdata[HALF_W-1:0];
      end
    end
  end

  // plain storage slots, one per generated register
  for (genvar g = 0; g < N_SLOT; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ[g] <= '0;
      else if (busWe && hit(busAddr, OFS_SLOT0 + 4*g))
        slotQ[g] <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (hit(busAddr, OFS_CFG))    busRdata = cfgQ;
    if (hit(busAddr, OFS_MODEA))  busRdata = modeAQ;
    if (hit(busAddr, OFS_MODEB))  busRdata = modeBQ;
    if (hit(busAddr, OFS_CTRL))   busRdata = ctrlQ;
    if (hit(busAddr, OFS_MASK))   busRdata = DATA_W'(maskQ);
    if (hit(busAddr, OFS_RAW))    busRdata = DATA_W'(rawQ);
    if (hit(busAddr, OFS_MSTAT))  busRdata = DATA_W'(rawQ & maskQ);
    if (hit(busAddr, OFS_IVL))    busRdata = {splitOff ? ivlHiQ : '0, ivlLoQ};
    if (hit(busAddr, OFS_IVLHI))  busRdata = DATA_W'(ivlHiQ);
    if (hit(busAddr, OFS_MATCH))  busRdata = {splitOff ? matHiQ : '0, matLoQ};
    if (hit(busAddr, OFS_MATCHI)) busRdata = DATA_W'(matHiQ);
    for (int i = 0; i < N_SLOT; i++)
      if (hit(busAddr, OFS_SLOT0 + 4*i)) busRdata = slotQ[i];
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [2*HALF_W-1:0]  busWdata,
  output logic [2*HALF_W-1:0]  busRdata,
  input  logic                 secTick,
  output logic                 irqOut,
  output logic                 adcTrig
);
  localparam int DATA_W = 2 * HALF_W;

  gptStrobe_t        stb;
  gptEvent_t         evt;
  logic [DATA_W-1:0] reloadVal;
  logic [DATA_W-1:0] matchVal;

  gpt_regs #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .secTick(secTick),
    .evt(evt), .stb(stb), .reloadVal(reloadVal), .matchVal(matchVal),
    .irqOut(irqOut), .adcTrig(adcTrig)
  );

  gpt_dp #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reloadVal(reloadVal),
    .matchVal(matchVal), .evt(evt)
  );
endmodule

// File: rtl/gpt_chk.sv
module gpt_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              adcTrig
);
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'('h24)) |-> (busRdata == '0)); // R2

  AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h18) && busWdata[6:0] == 7'h0) |=> !irqOut); // R11

  AST_STOP_NO_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h0C) && !busWdata[0]) |=> !adcTrig); // R9

  AST_TRIG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h0C) && !busWdata[5]) ##1
    !(busWe && busAddr == ADDR_W'('h0C)) |=> !adcTrig); // R7

  AST_MASK_NO_BIT3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'('h18)) |-> (busRdata[3] == 1'b0 && busRdata[DATA_W-1:7] == '0)); // R10
endmodule

bind gp_timer gpt_chk #(.ADDR_W(ADDR_W), .DATA_W(2*HALF_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .adcTrig(adcTrig)
);

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        secTick = 1'b0;
  logic        irqOut, adcTrig;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  gp_timer u_gp_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .secTick(secTick),
    .irqOut(irqOut), .adcTrig(adcTrig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] mCfg, mModeA, mModeB, mCtrl;
  logic [6:0]  mMask, mRaw;
  logic [15:0] mLo, mHi, mMlo, mMhi;
  logic [31:0] mSlot [4];
  longint      mCnt, mRtc;
  bit          mTrig;

  task automatic modelReset();
    mCfg = 0; mModeA = 0; mModeB = 0; mCtrl = 0; mMask = 0; mRaw = 0;
    mLo = 0; mHi = 0; mMlo = 0; mMhi = 0; mCnt = 0; mRtc = 0; mTrig = 0;
    for (int i = 0; i < 4; i++) mSlot[i] = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      longint ivl, mat, nxt;
      bit ctrlW, act, hitTo;
      logic [6:0] sets, clr;
      logic [31:0] newCtrl;
      ivl = longint'({mHi, mLo});
      mat = longint'({mMhi, mMlo});
      ctrlW = busWe && busAddr == 8'h0C;
      act = mCtrl[0] && !(ctrlW && !busWdata[0]);
      sets = 0; hitTo = 0;
      if (act && mCfg == 0) begin
        if (mCnt <= 1) begin hitTo = 1; mCnt = ivl; end
        else mCnt = mCnt - 1;
      end
      if (act && mCfg == 1 && secTick) begin
        nxt = mRtc + 1;
        if (nxt > mat) nxt = 0;
        mRtc = nxt;
        if (nxt == 0) sets[3] = 1;
      end
      if (ctrlW && busWdata[0] && !mCtrl[0]) mCnt = ivl;
      if (hitTo) sets[0] = 1;
      mTrig = hitTo && mCtrl[5];
      clr = (busWe && busAddr == 8'h24) ? busWdata[6:0] : 7'h0;
      newCtrl = mCtrl;
      if (hitTo && mModeA[0]) newCtrl[0] = 0;
      if (busWe) begin
        case (busAddr)
          8'h00: mCfg = busWdata;
          8'h04: mModeA = busWdata;
          8'h08: mModeB = busWdata;
          8'h0C: newCtrl = busWdata;
          8'h18: mMask = busWdata[6:0] & 7'h77;
          8'h28: begin mLo = busWdata[15:0]; if (mCfg < 4) mHi = busWdata[31:16]; end
          8'h2C: mHi = busWdata[15:0];
          8'h30: begin mMlo = busWdata[15:0]; if (mCfg < 4) mMhi = busWdata[31:16]; end
          8'h34: mMhi = busWdata[15:0];
          8'h38: mSlot[0] = busWdata;
          8'h3C: mSlot[1] = busWdata;
          8'h40: mSlot[2] = busWdata;
          8'h44: mSlot[3] = busWdata;
          default: ;
        endcase
      end
      mCtrl = newCtrl;
      mRaw = (mRaw & ~clr) | sets;
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mCfg;
      8'h04: return mModeA;
      8'h08: return mModeB;
      8'h0C: return mCtrl;
      8'h18: return 32'(mMask);
      8'h1C: return 32'(mRaw);
      8'h20: return 32'(mRaw & mMask);
      8'h28: return {(mCfg < 4) ? mHi : 16'h0, mLo};
      8'h2C: return 32'(mHi);
      8'h30: return {(mCfg < 4) ? mMhi : 16'h0, mMlo};
      8'h34: return 32'(mMhi);
      8'h38: return mSlot[0];
      8'h3C: return mSlot[1];
      8'h40: return mSlot[2];
      8'h44: return mSlot[3];
      default: return 32'h0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(busRdata, modelRead(busAddr), {curReq, " rdata"});
    chk(32'(irqOut), 32'(|(mRaw & mMask)), {curReq, " irq R11"});
    chk(32'(adcTrig), 32'(mTrig), {curReq, " trig R7"});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    busAddr = a;
    #1;
    chk(busRdata, exp, req);
  endtask

  // count ticks until adcTrig is seen, up to lim; returns lim+1 when none
  task automatic waitTrig(input int lim, output int k);
    k = lim + 1;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (adcTrig && k > lim) begin k = i; return; end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int k;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    curReq = "R1";
    rd(8'h00, 0, "R1 cfg"); rd(8'h0C, 0, "R1 ctrl"); rd(8'h28, 0, "R1 interval");
    rd(8'h1C, 0, "R1 raw"); rd(8'h18, 0, "R1 mask");
    chk(32'(irqOut), 0, "R1 irq"); chk(32'(adcTrig), 0, "R1 trig");

    curReq = "R2";
    wr(8'h04, 32'hDEAD_BEEF); wr(8'h08, 32'h1234_5678); wr(8'h40, 32'hCAFE_F00D);
    rd(8'h04, 32'hDEAD_BEEF, "R2 modeA"); rd(8'h08, 32'h1234_5678, "R2 modeB");
    rd(8'h40, 32'hCAFE_F00D, "R2 slot2"); rd(8'h24, 0, "R2 clear reads 0");
    rd(8'h7C, 0, "R2 unmapped");
    wr(8'h04, 0);

    curReq = "R3";
    wr(8'h28, 32'h0003_0005);
    rd(8'h28, 32'h0003_0005, "R3 interval both halves");
    wr(8'h00, 4);
    wr(8'h28, 32'hAAAA_1234);
    rd(8'h28, 32'h0000_1234, "R3 split read hides high");
    rd(8'h2C, 32'h0000_0003, "R3 high half kept");
    wr(8'h34, 32'h0000_0077);
    rd(8'h34, 32'h0000_0077, "R3 match high");
    wr(8'h00, 0);
    wr(8'h28, 5);

    curReq = "R4";
    wr(8'h18, 32'hFF);
    rd(8'h18, 32'h77, "R10 mask keeps 0x77");
    wr(8'h0C, 32'h21);
    waitTrig(20, k); chk(k, 5, "R4 first timeout after N");
    rd(8'h1C, 1, "R6 raw bit0 set");
    chk(32'(irqOut), 1, "R11 irq with bit0 masked");
    waitTrig(20, k); chk(k, 5, "R4 periodic reload N");
    tick();
    chk(32'(adcTrig), 0, "R7 single cycle pulse");

    curReq = "R9";
    wr(8'h0C, 0);
    waitTrig(15, k); chk(k, 16, "R9 stopped timer idle");
    curReq = "R12";
    wr(8'h24, 1);
    rd(8'h1C, 0, "R12 clear bit0");
    chk(32'(irqOut), 0, "R12 irq drops");

    curReq = "R4";
    wr(8'h28, 1);
    wr(8'h0C, 32'h21);
    waitTrig(5, k); chk(k, 1, "R4 interval 1 each cycle");
    waitTrig(5, k); chk(k, 1, "R4 interval 1 again");
    wr(8'h0C, 0);

    curReq = "R5";
    wr(8'h28, 3); wr(8'h04, 1);
    wr(8'h0C, 32'h21);
    waitTrig(10, k); chk(k, 3, "R5 one-shot timeout");
    rd(8'h0C, 32'h20, "R5 run bit cleared");
    waitTrig(12, k); chk(k, 13, "R5 no further timeouts");
    wr(8'h04, 0);

    curReq = "R7";
    wr(8'h24, 32'h7F);
    wr(8'h28, 4); wr(8'h0C, 32'h01);
    waitTrig(10, k); chk(k, 11, "R7 no pulse with bit5 clear");
    rd(8'h1C, 1, "R6 raw set without trigger");
    wr(8'h0C, 0);

    curReq = "R8";
    wr(8'h24, 32'h7F);
    wr(8'h00, 1); wr(8'h30, 2); wr(8'h0C, 32'h21);
    for (int i = 0; i < 2; i++) begin secTick = 1; tick(); secTick = 0; tick(); end
    rd(8'h1C, 0, "R8 no wrap at count 2");
    secTick = 1; tick(); secTick = 0;
    rd(8'h1C, 8, "R8 wrap sets bit3");
    chk(32'(irqOut), 0, "R10 bit3 never interrupts");
    chk(32'(adcTrig), 0, "R8 no trigger in seconds mode");
    wr(8'h0C, 0);

    curReq = "R13";
    wr(8'h24, 32'h7F);
    wr(8'h00, 2); wr(8'h28, 1); wr(8'h0C, 32'h21);
    waitTrig(20, k); chk(k, 21, "R13 idle config");
    rd(8'h1C, 0, "R13 no status");
    wr(8'h0C, 0); wr(8'h00, 0);

    // random traffic, model compared every cycle
    curReq = "R12 random";
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] offs [13];
      offs = '{8'h00, 8'h04, 8'h0C, 8'h0C, 8'h18, 8'h1C, 8'h20, 8'h24,
               8'h28, 8'h2C, 8'h30, 8'h34, 8'h38};
      busAddr = offs[$urandom % 13];
      busWe = ($urandom % 4) == 0;
      busWdata = $urandom;
      if (busAddr == 8'h00) busWdata = $urandom % 3;
      if (busAddr == 8'h28 || busAddr == 8'h30) busWdata = $urandom % 12;
      if (busAddr == 8'h2C || busAddr == 8'h34) busWdata = 0;
      secTick = ($urandom % 3) == 0;
      tick();
    end
    busWe = 0; secTick = 0;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule